// File: doc/BRIEF.md
# Multi-Mode Serial Receiver with Status Flags

This block takes in serial data in one of three modes, chosen by `mode_sel`. Two modes are asynchronous and one is clocked synchronous. The asynchronous framer samples the line at sixteen times the bit rate. The sample tick comes from a plain divider, `DIV` system clocks per tick. A frame is a low start bit, eight data bits sent least significant bit first, then an optional extra slot, then a high stop bit. In normal mode the extra slot holds a parity bit and is present only when parity is on. In multiprocessor mode the slot is always present and holds an address/data marker. In synchronous mode, each rising edge of an external shift clock shifts in one data bit, least significant bit first. There is no start bit and no stop bit.

Every completed frame goes to a status stage. That stage loads the data register and keeps a receive-full flag and three sticky error flags: parity, overrun and framing. It also drives one interrupt line. The mode decides two things: when receive-full sets, and which error flags can set at all. A read strobe takes the byte and clears receive-full. An error-clear strobe clears the error flags.

Top module: `sio_rx_unit`

## Requirements
- R1: `rx_irq` is 1 exactly when `flag_full` or any of `flag_par`, `flag_ovr`, `flag_frm` is 1. After reset all flags, `rx_irq`, `rx_valid` and `rx_data` are 0.
- R2: In asynchronous normal mode (`mode_sel`=00), the byte is loaded into `rx_data` and `flag_full` sets once the stop bit has been sampled. A bit lasts 16*`DIV` clocks and each bit is sampled at mid-bit.
- R3: In mode 00 with `par_en`=1, a parity slot follows the data. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. A mismatch sets `flag_par`.
- R4: In asynchronous multiprocessor mode (`mode_sel`=01), the slot after the data is a marker bit, and it is shown on `mp_marker` once the frame is loaded. `flag_par` never sets in this mode, whatever `par_en` is.
- R5: In modes 00 and 01, a stop bit that is low at mid-bit sets `flag_frm`.
- R6: A low level on the idle line that is gone by the middle of the start bit is rejected. No frame is received.
- R7: In synchronous mode (`mode_sel`=1x), `rxd` is sampled on each rising edge of `sclk_ext`, least significant bit first. `flag_full` sets right after the eighth bit. `flag_par` and `flag_frm` never set in this mode.
- R8: If a frame completes while `flag_full` is 1 and no read strobe is present, `flag_ovr` sets and `rx_data` keeps the old byte.
- R9: `rd_strobe` clears only `flag_full`. `err_clr` clears only the three error flags. Otherwise the flags hold.
- R10: `rx_valid` is 1 exactly when `flag_full` is 1 and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial data line, idle high |
| sclk_ext | input | 1 | External shift clock for synchronous mode |
| mode_sel | input | 2 | 00 async normal, 01 async multiprocessor, 1x synchronous |
| par_en | input | 1 | Parity slot enable (mode 00) |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| rd_strobe | input | 1 | Data register read, clears receive-full |
| err_clr | input | 1 | Clears all error flags |
| rx_data | output | 8 | Received data register |
| rx_valid | output | 1 | Data register full and free of errors |
| flag_full | output | 1 | Receive-full flag |
| flag_par | output | 1 | Parity error flag |
| flag_ovr | output | 1 | Overrun error flag |
| flag_frm | output | 1 | Framing error flag |
| mp_marker | output | 1 | Address/data marker of the last loaded multiprocessor frame |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
On every cycle, the assertions check that the flags behave according to the mode. Parity errors can rise only in normal mode, and framing errors never rise in synchronous mode. Flags fall only in response to their own strobe, the data register stays frozen while it is full and when an overrun hits, and `rx_valid` is never high alongside an error flag. Other behaviour shows only in the bench scenarios: the bit order, the parity arithmetic, which slot carries the marker, glitch rejection at the start bit, and the point at which receive-full sets in each mode. The bench sweeps bytes in every mode and compares them against values it computes itself.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OVS    = 16;

  localparam logic [1:0] MODE_NORM = 2'b00;
  localparam logic [1:0] MODE_MP   = 2'b01;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_EXTRA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/sio_rx_async.sv
module sio_rx_async
  import sio_rx_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              extra_en,
  input  logic              line,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              extra_bit,
  output logic              stop_bit
);
  localparam int unsigned DIV_W = $clog2(DIV);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam int unsigned HALF  = OVS / 2;

  logic [DIV_W-1:0]  div_q, div_n;
  logic              tick;
  rx_state_t         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BIT_W-1:0]  bits_q, bits_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              ext_q, ext_n, stp_q, stp_n, done_q, done_n;

  assign tick  = (div_q == DIV_W'(DIV - 1));
  assign div_n = (!en || tick) ? '0 : div_q + 1'b1;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    bits_n = bits_q;
    sh_n   = sh_q;
    ext_n  = ext_q;
    stp_n  = stp_q;
    done_n = 1'b0;
    if (!en) begin
      st_n  = RX_IDLE;
      cnt_n = '0;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!line) begin
            st_n  = RX_START;
            cnt_n = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CNT_W'(HALF - 1)) begin
            cnt_n  = '0;
            bits_n = '0;
            st_n   = line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CNT_W'(OVS - 1)) begin
            cnt_n = '0;
            sh_n  = {line, sh_q[DATA_W-1:1]};
            if (bits_q == BIT_W'(DATA_W - 1)) st_n = extra_en ? RX_EXTRA : RX_STOP;
            else                              bits_n = bits_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_EXTRA: begin
          if (cnt_q == CNT_W'(OVS - 1)) begin
            cnt_n = '0;
            ext_n = line;
            st_n  = RX_STOP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CNT_W'(OVS - 1)) begin
            cnt_n  = '0;
            stp_n  = line;
            done_n = 1'b1;
            st_n   = RX_IDLE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bits_q <= '0;
      sh_q   <= '0;
      ext_q  <= 1'b0;
      stp_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      div_q  <= div_n;
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bits_q <= bits_n;
      sh_q   <= sh_n;
      ext_q  <= ext_n;
      stp_q  <= stp_n;
      done_q <= done_n;
    end
  end

  assign done      = done_q;
  assign data      = sh_q;
  assign extra_bit = ext_q;
  assign stop_bit  = stp_q;
endmodule

// File: rtl/sio_rx_clocked.sv
module sio_rx_clocked
  import sio_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sclk_s,
  input  logic              sd_s,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam int unsigned BIT_W = $clog2(DATA_W);

  logic              sclk_d_q;
  logic              rise;
  logic [BIT_W-1:0]  bits_q, bits_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              done_q, done_n;

  assign rise = sclk_s & ~sclk_d_q;

  always_comb begin
    bits_n = bits_q;
    sh_n   = sh_q;
    done_n = 1'b0;
    if (!en) begin
      bits_n = '0;
    end else if (rise) begin
      sh_n = {sd_s, sh_q[DATA_W-1:1]};
      if (bits_q == BIT_W'(DATA_W - 1)) begin
        bits_n = '0;
        done_n = 1'b1;
      end else begin
        bits_n = bits_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      bits_q   <= '0;
      sh_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      bits_q   <= bits_n;
      sh_q     <= sh_n;
      done_q   <= done_n;
    end
  end

  assign done = done_q;
  assign data = sh_q;
endmodule

// File: rtl/sio_rx_status.sv
module sio_rx_status
  import sio_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              a_done,
  input  logic [DATA_W-1:0] a_data,
  input  logic              a_extra,
  input  logic              a_stop,
  input  logic              s_done,
  input  logic [DATA_W-1:0] s_data,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              perr,
  output logic              oerr,
  output logic              ferr,
  output logic              marker
);
  logic              is_sync, fr_done, keep, accept, par_bad, frm_bad;
  logic [DATA_W-1:0] fr_byte;
  logic [DATA_W-1:0] data_q, data_n;
  logic              full_q, full_n, per_q, per_n, ovr_q, ovr_n, frm_q, frm_n, mk_q, mk_n;

  assign is_sync = mode[1];
  assign fr_done = is_sync ? s_done : a_done;
  assign fr_byte = is_sync ? s_data : a_data;
  assign par_bad = (mode == MODE_NORM) & par_en & ((^{a_data, a_extra}) ^ par_odd);
  assign frm_bad = ~is_sync & ~a_stop;
  assign keep    = full_q & ~rd_strobe;
  assign accept  = fr_done & ~keep;

  always_comb begin
    data_n = data_q;
    mk_n   = mk_q;
    full_n = rd_strobe ? 1'b0 : full_q;
    per_n  = err_clr ? 1'b0 : per_q;
    ovr_n  = err_clr ? 1'b0 : ovr_q;
    frm_n  = err_clr ? 1'b0 : frm_q;
    if (accept) begin
      data_n = fr_byte;
      mk_n   = (mode == MODE_MP) & a_extra;
      full_n = 1'b1;
      per_n  = per_n | par_bad;
      frm_n  = frm_n | frm_bad;
    end else if (fr_done) begin
      ovr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mk_q   <= 1'b0;
      full_q <= 1'b0;
      per_q  <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      mk_q   <= mk_n;
      full_q <= full_n;
      per_q  <= per_n;
      ovr_q  <= ovr_n;
      frm_q  <= frm_n;
    end
  end

  assign data   = data_q;
  assign full   = full_q;
  assign perr   = per_q;
  assign oerr   = ovr_q;
  assign ferr   = frm_q;
  assign marker = mk_q;
endmodule

// File: rtl/sio_rx_unit.sv
module sio_rx_unit
  import sio_rx_pkg::*;
#(
  parameter int unsigned DIV       = 4,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              sclk_ext,
  input  logic [1:0]        mode_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              flag_full,
  output logic              flag_par,
  output logic              flag_ovr,
  output logic              flag_frm,
  output logic              mp_marker,
  output logic              rx_irq
);
  logic              rxd_s, sclk_s;
  logic              a_en, a_extra_en, a_done, a_extra, a_stop, s_done;
  logic [DATA_W-1:0] a_data, s_data;

  assign a_en       = ~mode_sel[1];
  assign a_extra_en = a_en & (mode_sel[0] | par_en);

  sio_rx_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  sio_rx_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .d(sclk_ext), .q(sclk_s)
  );

  sio_rx_async #(.DIV(DIV)) u_async (
    .clk(clk), .rst_n(rst_n), .en(a_en), .extra_en(a_extra_en), .line(rxd_s),
    .done(a_done), .data(a_data), .extra_bit(a_extra), .stop_bit(a_stop)
  );

  sio_rx_clocked u_clocked (
    .clk(clk), .rst_n(rst_n), .en(mode_sel[1]), .sclk_s(sclk_s), .sd_s(rxd_s),
    .done(s_done), .data(s_data)
  );

  sio_rx_status u_status (
    .clk(clk), .rst_n(rst_n), .mode(mode_sel), .par_en(par_en), .par_odd(par_odd),
    .a_done(a_done), .a_data(a_data), .a_extra(a_extra), .a_stop(a_stop),
    .s_done(s_done), .s_data(s_data), .rd_strobe(rd_strobe), .err_clr(err_clr),
    .data(rx_data), .full(flag_full), .perr(flag_par), .oerr(flag_ovr),
    .ferr(flag_frm), .marker(mp_marker)
  );

  assign rx_valid = flag_full & ~(flag_par | flag_ovr | flag_frm);
  assign rx_irq   = flag_full | flag_par | flag_ovr | flag_frm;
endmodule

// File: rtl/sio_rx_unit_chk.sv
module sio_rx_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       rd_strobe,
  input logic       err_clr,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       flag_full,
  input logic       flag_par,
  input logic       flag_ovr,
  input logic       flag_frm,
  input logic       rx_irq
);
  AST_VALID_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !(flag_par || flag_ovr || flag_frm)); // R10
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_irq) |-> ($past(rd_strobe) || $past(err_clr))); // R1
  AST_PAR_NORMAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_par) |-> ($past(mode_sel) == 2'b00)); // R4
  AST_FRM_NOT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_frm) |-> !$past(mode_sel[1])); // R7
  AST_OVR_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovr) |-> $stable(rx_data)); // R8
  AST_FULL_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_full) && !$past(rd_strobe)) |-> $stable(rx_data)); // R8
  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_full) |-> $past(rd_strobe)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flag_par) || $fell(flag_ovr) || $fell(flag_frm)) |-> $past(err_clr)); // R9
endmodule

bind sio_rx_unit sio_rx_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rd_strobe(rd_strobe),
  .err_clr(err_clr), .rx_data(rx_data), .rx_valid(rx_valid), .flag_full(flag_full),
  .flag_par(flag_par), .flag_ovr(flag_ovr), .flag_frm(flag_frm), .rx_irq(rx_irq)
);

// File: tb/sio_rx_unit_bench.sv
`timescale 1ns/1ps
module sio_rx_unit_bench;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic       clk, rst_n, rxd, sclk_ext, par_en, par_odd, rd_strobe, err_clr;
  logic [1:0] mode_sel;
  logic [7:0] rx_data;
  logic       rx_valid, flag_full, flag_par, flag_ovr, flag_frm, mp_marker, rx_irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  sio_rx_unit #(.DIV(DIV)) u_sio_rx_unit (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .sclk_ext(sclk_ext), .mode_sel(mode_sel),
    .par_en(par_en), .par_odd(par_odd), .rd_strobe(rd_strobe), .err_clr(err_clr),
    .rx_data(rx_data), .rx_valid(rx_valid), .flag_full(flag_full), .flag_par(flag_par),
    .flag_ovr(flag_ovr), .flag_frm(flag_frm), .mp_marker(mp_marker), .rx_irq(rx_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    idle(2);
  endtask

  task automatic pulse_clr();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    idle(2);
  endtask

  task automatic send_async(input logic [7:0] b, input bit has_ext, input bit ext, input bit stp);
    @(negedge clk) rxd = 1'b0;
    idle(BIT);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      idle(BIT);
    end
    if (has_ext) begin
      rxd = ext;
      idle(BIT);
    end
    if (stp) begin
      rxd = 1'b1;
      idle(BIT);
    end else begin
      rxd = 1'b0;
      idle(BIT * 3 / 4);
      rxd = 1'b1;
    end
    idle(BIT * 2);
  endtask

  task automatic send_sync(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) begin rxd = b[i]; sclk_ext = 1'b0; end
      idle(4);
      sclk_ext = 1'b1;
      idle(4);
    end
    sclk_ext = 1'b0;
    idle(8);
  endtask

  task automatic expect_state(input string req, input logic [7:0] d, input bit f, input bit p,
                              input bit o, input bit fr);
    chk({req, " data"}, rx_data, d);
    chk({req, " full"}, flag_full, f);
    chk({req, " par"}, flag_par, p);
    chk({req, " ovr"}, flag_ovr, o);
    chk({req, " frm"}, flag_frm, fr);
    chk({"R10 valid ", req}, rx_valid, f & ~(p | o | fr));
    chk({"R1 irq ", req}, rx_irq, f | p | o | fr);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 190000);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] b, a;
    bit p;
    rst_n = 1'b0; rxd = 1'b1; sclk_ext = 1'b0; mode_sel = 2'b00;
    par_en = 1'b0; par_odd = 1'b0; rd_strobe = 1'b0; err_clr = 1'b0;
    idle(5);
    chk("R1 reset irq", rx_irq, 0);
    expect_state("R1 reset", 8'h00, 0, 0, 0, 0);
    @(negedge clk) rst_n = 1'b1;
    idle(BIT);

    // R2: normal mode, no parity
    for (int i = 0; i < 16; i++) begin
      b = 8'(i * 37 + 1);
      send_async(b, 0, 0, 1);
      expect_state("R2 async", b, 1, 0, 0, 0);
      pulse_rd();
      chk("R9 read clears full", flag_full, 0);
      chk("R1 irq idle", rx_irq, 0);
    end

    // R3: parity good and bad, even and odd
    par_en = 1'b1;
    for (int i = 0; i < 24; i++) begin
      b = 8'(i * 29 + 3);
      par_odd = i[0];
      p = (^b) ^ par_odd;
      if (i % 4 == 3) begin
        send_async(b, 1, ~p, 1);
        expect_state("R3 bad parity", b, 1, 1, 0, 0);
        pulse_clr();
        expect_state("R9 clr keeps full", b, 1, 0, 0, 0);
      end else begin
        send_async(b, 1, p, 1);
        expect_state("R3 good parity", b, 1, 0, 0, 0);
      end
      pulse_rd();
    end

    // R4: multiprocessor marker, parity never flagged
    mode_sel = 2'b01;
    for (int i = 0; i < 12; i++) begin
      b = 8'(i * 53 + 7);
      par_odd = i[1];
      send_async(b, 1, i[0], 1);
      expect_state("R4 mp frame", b, 1, 0, 0, 0);
      chk("R4 marker", mp_marker, i[0]);
      pulse_rd();
    end

    // R5: framing error in both asynchronous modes
    send_async(8'h3C, 1, 1, 0);
    expect_state("R5 mp framing", 8'h3C, 1, 0, 0, 1);
    pulse_clr();
    pulse_rd();
    mode_sel = 2'b00; par_en = 1'b0;
    send_async(8'hA5, 0, 0, 0);
    expect_state("R5 norm framing", 8'hA5, 1, 0, 0, 1);
    pulse_rd();
    expect_state("R9 frm sticky after read", 8'hA5, 0, 0, 0, 1);
    pulse_clr();

    // R6: short glitch on the idle line
    @(negedge clk) rxd = 1'b0;
    idle(6);
    rxd = 1'b1;
    idle(BIT * 12);
    expect_state("R6 glitch rejected", 8'hA5, 0, 0, 0, 0);

    // R8: async overrun keeps first byte
    send_async(8'h11, 0, 0, 1);
    send_async(8'hEE, 0, 0, 1);
    expect_state("R8 async overrun", 8'h11, 1, 0, 1, 0);
    pulse_clr();
    expect_state("R10 valid after clr", 8'h11, 1, 0, 0, 0);
    pulse_rd();

    // R7: synchronous sweep of every byte, parity enabled yet unreported
    mode_sel = 2'b10; par_en = 1'b1; par_odd = 1'b0;
    idle(4);
    for (int i = 0; i < 256; i++) begin
      b = 8'(i);
      send_sync(b);
      expect_state("R7 sync", b, 1, 0, 0, 0);
      pulse_rd();
    end

    // R8: synchronous overrun
    a = 8'h5A;
    send_sync(a);
    send_sync(8'hC3);
    expect_state("R8 sync overrun", a, 1, 0, 1, 0);
    pulse_rd();
    expect_state("R9 ovr sticky after read", a, 0, 0, 1, 0);
    pulse_clr();
    chk("R1 irq after clear", rx_irq, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule